// File: doc/BRIEF.md
# Kernel Segment Base Load Unit

This unit executes the privileged operation that loads a 16-bit segment selector into the GS segment register. The base address taken from the selected descriptor goes into a separate 64-bit kernel-base register, not into the GS cached base. The operation is started by a one-cycle `start` pulse. On that pulse the unit samples the selector, the current privilege level, the mode and prefix qualifiers, the feature-enable bit and the descriptor-table limit. It then screens the request and, when the selector is not null, reads the 8-byte descriptor through a request/valid memory port.

Every operation ends with a one-cycle `done` pulse. When `done` is high, `faultCode` shows either a successful commit or exactly one fault, and `errSel` carries the error selector. A successful commit updates the GS selector, the attribute and limit fields, the null marker and the kernel-base register. A fault updates none of them. The unit has no arithmetic flag outputs, so no outcome can alter flags.

Top module: `kgs_load_unit`

## Requirements
- R1: While reset is low and after it is released, `done`, `memReq`, `faultCode`, `errSel`, `gsSel`, `gsAttr`, `gsLimit`, `gsNull` and `kernBase` are all zero.
- R2: If the privilege level is nonzero, `longMode` is 0, `lockPfx` is 1 or `featEn` is 0, the unit reports `faultCode`=1 (invalid opcode) with `errSel`=0. It issues no memory request and leaves every GS output and `kernBase` unchanged.
- R3: A selector whose bits 15:2 are zero (0x0000 to 0x0003) is null. The unit writes the selector to `gsSel`, sets `gsNull`, loads zero into `kernBase` and `gsAttr`/`gsLimit`, issues no memory request, and reports `faultCode`=0 on the second clock edge after `start`.
- R4: For a non-null selector, let the index be selector bits 15:3. If index*8+7 exceeds `tblLimit`, the unit reports `faultCode`=2 (general protection) with `errSel` equal to the selector and issues no memory request. The value index*8+7 equal to `tblLimit` passes this check.
- R5: Otherwise `memReq` is high for exactly one cycle with `memAddr` = index*8. The unit then waits any number of cycles for a one-cycle `memValid` carrying the descriptor on `memData`.
- R6: The descriptor type nibble is in bits 43:40 and the S bit is bit 44. If S=0, or if the type is a code segment (bit 43=1) that is not readable (bit 41=0), the unit reports `faultCode`=2 with the selector.
- R7: If the selector RPL (bits 1:0) is greater than the descriptor DPL (bits 46:45), the unit reports `faultCode`=2 with the selector.
- R8: If the descriptor passes R6 and R7 but the present bit (bit 47) is 0, the unit reports `faultCode`=3 (not present) with the selector.
- R9: On success the unit reports `faultCode`=0 and `errSel`=0. It writes the selector to `gsSel`, clears `gsNull`, sets `gsAttr` = {bits 55:52, bits 47:40} and `gsLimit` = {bits 51:48, bits 15:0}, and sets `kernBase` = {32 zero bits, bits 63:56, bits 39:32, bits 31:16}.
- R10: Only one fault is reported, chosen in this priority order: invalid opcode, then table limit, then type/privilege, then not present.
- R11: `done` is high for exactly one cycle per operation. A `start` pulse that arrives while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins an operation when the unit is idle |
| selIn | input | 16 | Selector operand |
| cplIn | input | 2 | Current privilege level |
| longMode | input | 1 | 1 when the core runs in 64-bit mode |
| lockPfx | input | 1 | LOCK prefix present |
| featEn | input | 1 | Feature enable |
| tblLimit | input | 16 | Descriptor-table limit in bytes |
| memReq | output | 1 | Descriptor read request, one cycle |
| memAddr | output | 16 | Byte offset of the descriptor in the table |
| memValid | input | 1 | Descriptor data valid |
| memData | input | 64 | Descriptor data |
| done | output | 1 | Operation complete, one cycle |
| faultCode | output | 2 | 0 none, 1 invalid opcode, 2 general protection, 3 not present |
| errSel | output | 16 | Error selector of the last fault |
| gsSel | output | 16 | GS selector |
| gsAttr | output | 12 | GS attribute fields |
| gsLimit | output | 20 | GS limit field |
| gsNull | output | 1 | GS marked null |
| kernBase | output | 64 | Kernel-base register |

## Verification
The hardest situation to reach is a `start` pulse that arrives while the unit is stalled waiting for `memValid`. The bench brings it about by setting a long memory latency and then pulsing `start` with a different selector during the wait. The reference model must show that the stray pulse neither restarts the unit nor changes the committed selector. The fault-priority corners, a not-present descriptor with a bad type and an invalid-opcode case with a selector that also exceeds the limit, are built from chosen descriptors and are compared cycle by cycle.

// File: rtl/kgs_pkg.sv
package kgs_pkg;
  localparam int SEL_W  = 16;
  localparam int DESC_W = 64;
  localparam int KB_W   = 64;
  localparam int ATTR_W = 12;
  localparam int LIMF_W = 20;
  localparam int IDX_LSB = 3;

  typedef enum logic [1:0] {F_NONE = 2'd0, F_UD = 2'd1, F_GP = 2'd2, F_NP = 2'd3} fault_e;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_FETCH, S_WAIT, S_VERIFY, S_DONE
  } state_e;

  typedef struct packed {
    logic   capture;
    logic   loadDesc;
    logic   wrNull;
    logic   wrDesc;
    logic   wrFault;
    fault_e code;
  } strobe_t;

  typedef struct packed {
    logic udHit;
    logic isNull;
    logic limitBad;
    logic typeBad;
    logic privBad;
    logic notPresent;
  } status_t;
endpackage

// File: rtl/kgs_ctrl.sv
module kgs_ctrl
  import kgs_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    memValid,
  input  status_t st,
  output strobe_t stb,
  output logic    memReq,
  output logic    done
);
  state_e state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt = state;
    stb = '0;
    stb.code = F_NONE;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          stb.capture = 1'b1;
          nxt = S_CHECK;
        end
      end
      S_CHECK: begin
        if (st.udHit) begin
          stb.wrFault = 1'b1;
          stb.code = F_UD;
          nxt = S_DONE;
        end else if (st.isNull) begin
          stb.wrNull = 1'b1;
          nxt = S_DONE;
        end else if (st.limitBad) begin
          stb.wrFault = 1'b1;
          stb.code = F_GP;
          nxt = S_DONE;
        end else begin
          nxt = S_FETCH;
        end
      end
      S_FETCH: nxt = S_WAIT;
      S_WAIT: begin
        if (memValid) begin
          stb.loadDesc = 1'b1;
          nxt = S_VERIFY;
        end
      end
      S_VERIFY: begin
        if (st.typeBad || st.privBad) begin
          stb.wrFault = 1'b1;
          stb.code = F_GP;
        end else if (st.notPresent) begin
          stb.wrFault = 1'b1;
          stb.code = F_NP;
        end else begin
          stb.wrDesc = 1'b1;
        end
        nxt = S_DONE;
      end
      S_DONE: nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  assign memReq = (state == S_FETCH);
  assign done   = (state == S_DONE);
endmodule

// File: rtl/kgs_dpath.sv
module kgs_dpath
  import kgs_pkg::*;
#(
  parameter int LIM_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [SEL_W-1:0]   selIn,
  input  logic [1:0]         cplIn,
  input  logic               longMode,
  input  logic               lockPfx,
  input  logic               featEn,
  input  logic [LIM_W-1:0]   tblLimit,
  input  logic [DESC_W-1:0]  memData,
  output status_t            st,
  output logic [SEL_W-1:0]   memAddr,
  output logic [1:0]         faultCode,
  output logic [SEL_W-1:0]   errSel,
  output logic [SEL_W-1:0]   gsSel,
  output logic [ATTR_W-1:0]  gsAttr,
  output logic [LIMF_W-1:0]  gsLimit,
  output logic               gsNull,
  output logic [KB_W-1:0]    kernBase
);
  localparam int BASE_W = 32;
  localparam int OFF_W  = SEL_W > LIM_W ? SEL_W : LIM_W;

  logic [SEL_W-1:0]  selQ;
  logic              udQ;
  logic [LIM_W-1:0]  limQ;
  logic [DESC_W-1:0] descQ;

  // operand capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ  <= '0;
      udQ   <= 1'b0;
      limQ  <= '0;
      descQ <= '0;
    end else begin
      if (stb.capture) begin
        selQ <= selIn;
        udQ  <= (cplIn != 2'd0) || !longMode || lockPfx || !featEn;
        limQ <= tblLimit;
      end
      if (stb.loadDesc) descQ <= memData;
    end
  end

  // descriptor field extraction
  logic [3:0]        dType;
  logic              dSys;
  logic [1:0]        dDpl;
  logic              dPres;
  logic [BASE_W-1:0] dBase;
  logic [OFF_W-1:0]  lastByte;

  assign dType = descQ[43:40];
  assign dSys  = descQ[44];
  assign dDpl  = descQ[46:45];
  assign dPres = descQ[47];
  assign dBase = {descQ[63:56], descQ[39:32], descQ[31:16]};

  assign lastByte = OFF_W'({selQ[SEL_W-1:IDX_LSB], 3'b111});
  assign memAddr  = {selQ[SEL_W-1:IDX_LSB], 3'b000};

  assign st.udHit      = udQ;
  assign st.isNull     = (selQ[SEL_W-1:2] == '0);
  assign st.limitBad   = lastByte > OFF_W'(limQ);
  assign st.typeBad    = !dSys || (dType[3] && !dType[1]);
  assign st.privBad    = selQ[1:0] > dDpl;
  assign st.notPresent = !dPres;

  // architectural state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultCode <= F_NONE;
      errSel    <= '0;
      gsSel     <= '0;
      gsAttr    <= '0;
      gsLimit   <= '0;
      gsNull    <= 1'b0;
      kernBase  <= '0;
    end else if (stb.wrFault) begin
      faultCode <= stb.code;
      errSel    <= (stb.code == F_UD) ? '0 : selQ;
    end else if (stb.wrNull) begin
      faultCode <= F_NONE;
      errSel    <= '0;
      gsSel     <= selQ;
      gsAttr    <= '0;
      gsLimit   <= '0;
      gsNull    <= 1'b1;
      kernBase  <= '0;
    end else if (stb.wrDesc) begin
      faultCode <= F_NONE;
      errSel    <= '0;
      gsSel     <= selQ;
      gsAttr    <= {descQ[55:52], descQ[47:40]};
      gsLimit   <= {descQ[51:48], descQ[15:0]};
      gsNull    <= 1'b0;
      kernBase  <= {{(KB_W-BASE_W){1'b0}}, dBase};
    end
  end
endmodule

// File: rtl/kgs_load_unit.sv
module kgs_load_unit
  import kgs_pkg::*;
#(
  parameter int LIM_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [SEL_W-1:0]   selIn,
  input  logic [1:0]         cplIn,
  input  logic               longMode,
  input  logic               lockPfx,
  input  logic               featEn,
  input  logic [LIM_W-1:0]   tblLimit,
  output logic               memReq,
  output logic [SEL_W-1:0]   memAddr,
  input  logic               memValid,
  input  logic [DESC_W-1:0]  memData,
  output logic               done,
  output logic [1:0]         faultCode,
  output logic [SEL_W-1:0]   errSel,
  output logic [SEL_W-1:0]   gsSel,
  output logic [ATTR_W-1:0]  gsAttr,
  output logic [LIMF_W-1:0]  gsLimit,
  output logic               gsNull,
  output logic [KB_W-1:0]    kernBase
);
  strobe_t stb;
  status_t st;

  kgs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .memValid(memValid),
    .st(st), .stb(stb), .memReq(memReq), .done(done)
  );

  kgs_dpath #(.LIM_W(LIM_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .selIn(selIn), .cplIn(cplIn),
    .longMode(longMode), .lockPfx(lockPfx), .featEn(featEn),
    .tblLimit(tblLimit), .memData(memData), .st(st), .memAddr(memAddr),
    .faultCode(faultCode), .errSel(errSel), .gsSel(gsSel),
    .gsAttr(gsAttr), .gsLimit(gsLimit), .gsNull(gsNull), .kernBase(kernBase)
  );
endmodule

// File: rtl/kgs_load_chk.sv
module kgs_load_chk
  import kgs_pkg::*;
#(
  parameter int LIM_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic [SEL_W-1:0]   selIn,
  input logic [1:0]         cplIn,
  input logic               longMode,
  input logic               lockPfx,
  input logic               featEn,
  input logic [LIM_W-1:0]   tblLimit,
  input logic               memReq,
  input logic [SEL_W-1:0]   memAddr,
  input logic               memValid,
  input logic [DESC_W-1:0]  memData,
  input logic               done,
  input logic [1:0]         faultCode,
  input logic [SEL_W-1:0]   errSel,
  input logic [SEL_W-1:0]   gsSel,
  input logic [ATTR_W-1:0]  gsAttr,
  input logic [LIMF_W-1:0]  gsLimit,
  input logic               gsNull,
  input logic [KB_W-1:0]    kernBase
);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_req_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

  p_req_not_done_r11: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !done);

  p_fault_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (done && faultCode != F_NONE) |->
      ($stable(kernBase) && $stable(gsSel) && $stable(gsNull) && $stable(gsAttr)));

  p_null_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (done && faultCode == F_NONE && gsNull) |-> (kernBase == '0 && gsSel[SEL_W-1:2] == '0));

  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    kernBase[KB_W-1:32] == '0);

  p_sel_err_r4: assert property (@(posedge clk) disable iff (!rstN)
    (done && (faultCode == F_GP || faultCode == F_NP)) |-> errSel[SEL_W-1:2] != '0);

  p_ud_nosel_r2: assert property (@(posedge clk) disable iff (!rstN)
    (done && faultCode == F_UD) |-> errSel == '0);
endmodule

bind kgs_load_unit kgs_load_chk #(.LIM_W(LIM_W)) u_chk (.*);

// File: tb/sim_kgs_load_unit.sv
`timescale 1ns/1ps
module sim_kgs_load_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] selIn = '0;
  logic [1:0]  cplIn = '0;
  logic        longMode = 1'b1;
  logic        lockPfx = 1'b0;
  logic        featEn = 1'b1;
  logic [15:0] tblLimit = '0;
  logic        memReq;
  logic [15:0] memAddr;
  logic        memValid = 1'b0;
  logic [63:0] memData;
  logic        done;
  logic [1:0]  faultCode;
  logic [15:0] errSel;
  logic [15:0] gsSel;
  logic [11:0] gsAttr;
  logic [19:0] gsLimit;
  logic        gsNull;
  logic [63:0] kernBase;

  always #2 clk = ~clk;

  kgs_load_unit u0 (.*);

  int nChecks = 0;
  int nFail = 0;
  string curTag = "R1";
  logic [63:0] benchDesc = '0;
  int memLat = 0;
  assign memData = benchDesc;

  task automatic cmp(input string nm, input logic [63:0] a, input logic [63:0] e);
    nChecks++;
    if (a !== e) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", curTag, nm, a, e);
    end
  endtask

  // behavioural reference model, advanced on each rising edge
  int          mPh = 0;
  logic [15:0] mSel;
  logic        mUd;
  int          mLim;
  logic [63:0] mDesc;
  logic        eReq = 0, eDone = 0;
  logic [1:0]  eFault = 0;
  logic [15:0] eErr = 0, eGsSel = 0;
  logic [11:0] eAttr = 0;
  logic [19:0] eLimF = 0;
  logic        eNull = 0;
  logic [63:0] eKb = 0;

  task automatic mFault(input logic [1:0] c);
    eFault = c;
    eErr = (c == 2'd1) ? 16'h0 : mSel;
    mPh = 5;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mPh = 0; eFault = 0; eErr = 0; eGsSel = 0; eAttr = 0; eLimF = 0;
      eNull = 0; eKb = 0;
    end else begin
      case (mPh)
        0: if (start) begin
             mSel = selIn;
             mUd = (cplIn != 0) || !longMode || lockPfx || !featEn;
             mLim = int'(tblLimit);
             mPh = 1;
           end
        1: begin
             if (mUd) mFault(2'd1);
             else if (mSel < 16'd4) begin
               eFault = 0; eErr = 0; eGsSel = mSel; eAttr = 0; eLimF = 0;
               eNull = 1; eKb = 0; mPh = 5;
             end else if (int'(mSel >> 3) * 8 + 7 > mLim) mFault(2'd2);
             else mPh = 2;
           end
        2: mPh = 3;
        3: if (memValid) begin mDesc = memData; mPh = 4; end
        4: begin
             if (!mDesc[44] || (mDesc[43] && !mDesc[41]) ||
                 int'(mSel[1:0]) > int'(mDesc[46:45])) mFault(2'd2);
             else if (!mDesc[47]) mFault(2'd3);
             else begin
               eFault = 0; eErr = 0; eGsSel = mSel; eNull = 0;
               eAttr = {mDesc[55:52], mDesc[47:40]};
               eLimF = {mDesc[51:48], mDesc[15:0]};
               eKb = {32'h0, mDesc[63:56], mDesc[39:32], mDesc[31:16]};
               mPh = 5;
             end
           end
        default: mPh = 0;
      endcase
    end
    eReq  = (mPh == 2);
    eDone = (mPh == 5);
  end

  // compare on every falling edge
  always @(negedge clk) begin
    cmp("memReq", 64'(memReq), 64'(eReq));
    cmp("done", 64'(done), 64'(eDone));
    cmp("faultCode", 64'(faultCode), 64'(eFault));
    cmp("errSel", 64'(errSel), 64'(eErr));
    cmp("gsSel", 64'(gsSel), 64'(eGsSel));
    cmp("gsAttr", 64'(gsAttr), 64'(eAttr));
    cmp("gsLimit", 64'(gsLimit), 64'(eLimF));
    cmp("gsNull", 64'(gsNull), 64'(eNull));
    cmp("kernBase", kernBase, eKb);
    if (eReq) cmp("memAddr R5", 64'(memAddr), 64'({mSel[15:3], 3'b000}));
  end

  // memory responder
  bit waiting = 0;
  int cnt = 0;
  always @(negedge clk) begin
    memValid = 1'b0;
    if (memReq && !waiting) begin
      waiting = 1; cnt = memLat;
    end else if (waiting) begin
      if (cnt == 0) begin memValid = 1'b1; waiting = 0; end
      else cnt--;
    end
  end

  function automatic logic [63:0] mkDesc(input logic [31:0] base, input logic [3:0] typ,
      input logic s, input logic [1:0] dpl, input logic p);
    return {base[31:24], 4'hC, 4'h5, p, dpl, s, typ, base[23:16], base[15:0], 16'hBEEF};
  endfunction

  task automatic runOp(input string tag, input logic [15:0] sel, input logic [1:0] cpl,
      input logic lm, input logic lk, input logic fe, input logic [15:0] lim,
      input logic [63:0] desc, input int lat, input bit poke);
    curTag = tag; benchDesc = desc; memLat = lat;
    @(negedge clk);
    selIn = sel; cplIn = cpl; longMode = lm; lockPfx = lk; featEn = fe;
    tblLimit = lim; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      selIn = 16'h0003; start = 1'b1;   // arrives mid-operation
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (done) break;
    end
    repeat (2) @(negedge clk);
  endtask

  localparam logic [63:0] DATA_OK = 64'hA1C5_92B2_C3D4_BEEF;

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired in %s", curTag);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    curTag = "R1";
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R9 writable data segment, base 0xA1B2C3D4
    runOp("R9", 16'h002B, 0, 1, 0, 1, 16'h00FF, mkDesc(32'hA1B2C3D4, 4'h2, 1, 3, 1), 1, 0);
    // R2 each invalid-opcode condition leaves state intact
    runOp("R2", 16'h0010, 3, 1, 0, 1, 16'h00FF, mkDesc(32'h1, 4'h2, 1, 0, 1), 0, 0);
    runOp("R2", 16'h0010, 0, 0, 0, 1, 16'h00FF, mkDesc(32'h1, 4'h2, 1, 0, 1), 0, 0);
    runOp("R2", 16'h0010, 0, 1, 1, 1, 16'h00FF, mkDesc(32'h1, 4'h2, 1, 0, 1), 0, 0);
    runOp("R2", 16'h0010, 0, 1, 0, 0, 16'h00FF, mkDesc(32'h1, 4'h2, 1, 0, 1), 0, 0);
    // R3 null selectors
    for (int k = 0; k < 4; k++)
      runOp("R3", 16'(k), 0, 1, 0, 1, 16'h0000, DATA_OK, 0, 0);
    // R4 limit boundary: last byte 0x2F
    runOp("R4", 16'h0028, 0, 1, 0, 1, 16'h002E, DATA_OK, 0, 0);
    runOp("R4", 16'h0028, 0, 1, 0, 1, 16'h002F, mkDesc(32'h0BADF00D, 4'h3, 1, 0, 1), 0, 0);
    runOp("R4", 16'hFFF8, 0, 1, 0, 1, 16'hFFFE, DATA_OK, 0, 0);
    // R5 memory latencies
    runOp("R5", 16'h0040, 0, 1, 0, 1, 16'h0FFF, mkDesc(32'h12345678, 4'h0, 1, 0, 1), 0, 0);
    runOp("R5", 16'hFFF8, 0, 1, 0, 1, 16'hFFFF, mkDesc(32'h87654321, 4'h2, 1, 0, 1), 7, 0);
    // R6 type checks
    runOp("R6", 16'h0050, 0, 1, 0, 1, 16'h0FFF, mkDesc(32'h1111, 4'h2, 0, 0, 1), 2, 0);
    runOp("R6", 16'h0050, 0, 1, 0, 1, 16'h0FFF, mkDesc(32'h2222, 4'h8, 1, 0, 1), 2, 0);
    runOp("R6", 16'h0050, 0, 1, 0, 1, 16'h0FFF, mkDesc(32'h3333, 4'hA, 1, 0, 1), 2, 0);
    // R7 privilege
    runOp("R7", 16'h0053, 0, 1, 0, 1, 16'h0FFF, mkDesc(32'h4444, 4'h2, 1, 2, 1), 1, 0);
    runOp("R7", 16'h0050, 0, 1, 0, 1, 16'h0FFF, mkDesc(32'h5555, 4'h2, 1, 3, 1), 1, 0);
    // R8 not present
    runOp("R8", 16'h0058, 0, 1, 0, 1, 16'h0FFF, mkDesc(32'h6666, 4'h2, 1, 0, 0), 1, 0);
    // R10 priority corners
    runOp("R10", 16'h0058, 0, 1, 0, 1, 16'h0FFF, mkDesc(32'h7777, 4'h8, 1, 0, 0), 1, 0);
    runOp("R10", 16'h0800, 2, 1, 0, 1, 16'h0010, DATA_OK, 0, 0);
    // R11 stray start during a long wait is ignored
    runOp("R11", 16'h0060, 0, 1, 0, 1, 16'h0FFF, mkDesc(32'h89ABCDEF, 4'h2, 1, 0, 1), 8, 1);
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule